// File: doc/BRIEF.md
# Interrupt Request Routing Crossbar

This block sits between a large pool of peripheral interrupt request lines and a downstream interrupt controller that has far fewer inputs. Each controller input (an "output line" of this block) owns one select register. The register holds the number of the source line routed to that output. Software writes the select registers over a plain memory-mapped register port. The routing path from source to output is purely combinational.

The select registers all have the same width, fixed at build time to 1, 2 or 4 bytes. They sit back to back in a fixed byte window, so the number of output lines is the window size divided by the register size, rounded down. A build-time mask marks some outputs as reserved, and a second mask marks others as hard-wired. Both kinds bypass the mux and take a dedicated input line instead. Their registers never change. Any output that has not been programmed stays on a configurable safe source number.

Top module: `irq_route_xbar`

## Requirements
- R1: The block has WIN_BYTES/REG_BYTES output lines (152 with the defaults of 304 bytes and 2-byte registers). Output n's select register sits at byte offset n*REG_BYTES. A write at an offset past the last register changes nothing, and a read there returns 0.
- R2: For an output that is not bypassed, irq_out[n] equals src_irq[s], where s is the value held in output n's select register.
- R3: A write accepted on a clock edge is visible in the register and in the routing from that edge on. Before that edge the old value holds. Registers that are not addressed keep their values.
- R4: While rst_n is low, and after reset until written, every select register holds SAFE_IDX (default 0). Unprogrammed outputs therefore follow src_irq[SAFE_IDX].
- R5: A select value at or above NUM_SRC drives the output low, whatever the sources do.
- R6: A reserved output (a bit set in RSV_MASK; defaults are outputs 0 to 3) is driven by fixed_irq[n]. Writes to its register are ignored, and reads of it return SAFE_IDX.
- R7: A hard-wired output (a bit set in SKIP_MASK; defaults are outputs 10 and 100) has a register slot but is driven by fixed_irq[n]. A write to that register does not change the output or the read value, which stays SAFE_IDX.
- R8: A register keeps only the low 8*REG_BYTES bits of wdata, and rdata returns the stored value zero-extended to 32 bits.
- R9: The register number is the byte address divided by REG_BYTES. The low address bits inside a register are ignored, so a write at offset 41 lands in register 20 when REG_BYTES is 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| addr | input | AW (10) | Byte offset into the register window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for addr |
| src_irq | input | NUM_SRC (400) | Peripheral interrupt source lines |
| fixed_irq | input | NUM_OUT (152) | Dedicated lines for reserved and hard-wired outputs |
| irq_out | output | NUM_OUT (152) | Lines to the downstream interrupt controller |

## Verification
The assertions assume that the reset is applied at time zero and held across at least one rising edge. They also assume that wr_en, addr and wdata are settled around each rising edge. The bench changes every input on the falling edge and asserts reset from the first instant, so both assumptions hold. The assertions also take the source and fixed lines as plain levels with no timing relation to the clock. The bench changes these lines only between edges and samples irq_out a little after each change.

// File: rtl/irq_route_xbar.sv
module irq_route_xbar #(
  parameter int NUM_SRC   = 400,
  parameter int WIN_BYTES = 304,
  parameter int REG_BYTES = 2,
  parameter int SAFE_IDX  = 0,
  parameter logic [511:0] RSV_MASK  = 512'hF,
  parameter logic [511:0] SKIP_MASK = (512'd1 << 10) | (512'd1 << 100),
  localparam int NUM_OUT = WIN_BYTES / REG_BYTES,
  localparam int AW      = $clog2(WIN_BYTES) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      addr,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata,
  input  logic [NUM_SRC-1:0] src_irq,
  input  logic [NUM_OUT-1:0] fixed_irq,
  output logic [NUM_OUT-1:0] irq_out
);
  localparam int RW = 8 * REG_BYTES;
  localparam int SW = $clog2(NUM_SRC);
  localparam logic [511:0] BYP = RSV_MASK | SKIP_MASK;

  logic [RW-1:0] sel_q [NUM_OUT];
  logic [AW-1:0] idx;
  logic          hit;

  assign idx = addr / AW'(REG_BYTES);
  assign hit = 32'(idx) < NUM_OUT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_OUT; i++) sel_q[i] <= RW'(SAFE_IDX);
    end else if (wr_en && hit && !BYP[idx]) begin
      sel_q[idx] <= wdata[RW-1:0];
    end
  end

  assign rdata = hit ? 32'(sel_q[idx]) : 32'd0;

  always_comb begin
    for (int i = 0; i < NUM_OUT; i++) begin
      logic [31:0] sv;
      sv = 32'(sel_q[i]);
      if (BYP[i])            irq_out[i] = fixed_irq[i];
      else if (sv < NUM_SRC) irq_out[i] = src_irq[sv[SW-1:0]];
      else                   irq_out[i] = 1'b0;
    end
  end

  // R3
  wr_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit && !BYP[idx]) |=> sel_q[$past(idx)] == $past(wdata[RW-1:0]));

  // R4
  rst_safe_chk: assert property (@(posedge clk)
    (!rst_n && hit) |-> rdata == 32'(RW'(SAFE_IDX)));

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_chk
    // R3
    hold_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && hit && 32'(idx) == g) |=> $stable(sel_q[g]));
    if (BYP[g]) begin : g_byp
      // R6
      byp_wr_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && 32'(idx) == g) |=> $stable(sel_q[g]));
    end else begin : g_mux
      // R5
      oob_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(sel_q[g]) >= NUM_SRC) |-> !irq_out[g]);
    end
  end
endmodule

// File: tb/irq_route_xbar_tb_top.sv
module irq_route_xbar_tb_top;
  localparam int NS = 400;
  localparam int NO = 152;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          wr_en = 0;
  logic [9:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NS-1:0] src_irq = '0;
  logic [NO-1:0] fixed_irq = '0;
  logic [NO-1:0] irq_out;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  irq_route_xbar dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .src_irq(src_irq), .fixed_irq(fixed_irq),
    .irq_out(irq_out));

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = 10'(a); wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    addr = 10'(a); #1; d = rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(40, d); check(d == 0, "R4 reset value", d, 0);
    src_irq = '0; src_irq[0] = 1; #1;
    check(irq_out[20] == 1, "R4 safe routing high", irq_out[20], 1);
    src_irq[0] = 0; #1;
    check(irq_out[20] == 0, "R4 safe routing low", irq_out[20], 0);
  endtask

  task automatic t_route;
    logic [31:0] d;
    @(negedge clk); wr_en = 1; addr = 40; wdata = 7;
    #1; d = rdata; check(d == 0, "R3 old value before edge", d, 0);
    @(negedge clk); wr_en = 0; #1; d = rdata;
    check(d == 7, "R3 new value after edge", d, 7);
    src_irq = '0; src_irq[7] = 1; #1;
    check(irq_out[20] == 1, "R2 route src7", irq_out[20], 1);
    src_irq = ~src_irq; #1;
    check(irq_out[20] == 0, "R2 route inverted", irq_out[20], 0);
    wr(302, 399); src_irq = '0; src_irq[399] = 1; #1;
    check(irq_out[151] == 1, "R1 R2 last output last source", irq_out[151], 1);
    rd(40, d); check(d == 7, "R3 unaddressed reg kept", d, 7);
  endtask

  task automatic t_oob;
    logic [31:0] d;
    wr(60, 400); src_irq = '1; #1;
    check(irq_out[30] == 0, "R5 select 400 low", irq_out[30], 0);
    rd(60, d); check(d == 400, "R5 readback 400", d, 400);
    wr(62, 32'hFFFF); #1;
    check(irq_out[31] == 0, "R5 select ffff low", irq_out[31], 0);
  endtask

  task automatic t_bypass;
    logic [31:0] d;
    wr(4, 5); fixed_irq = '0; src_irq = '1; #1;
    check(irq_out[2] == 0, "R6 reserved follows fixed low", irq_out[2], 0);
    fixed_irq[2] = 1; #1;
    check(irq_out[2] == 1, "R6 reserved follows fixed high", irq_out[2], 1);
    rd(4, d); check(d == 0, "R6 reserved read safe", d, 0);
    wr(20, 9); fixed_irq[10] = 0; src_irq = '0; src_irq[9] = 1; #1;
    check(irq_out[10] == 0, "R7 hard-wired ignores write", irq_out[10], 0);
    fixed_irq[10] = 1; #1;
    check(irq_out[10] == 1, "R7 hard-wired follows fixed", irq_out[10], 1);
    rd(20, d); check(d == 0, "R7 hard-wired read safe", d, 0);
    wr(200, 3); rd(200, d); check(d == 0, "R7 output 100 read safe", d, 0);
  endtask

  task automatic t_window;
    logic [31:0] d;
    wr(304, 12); rd(304, d); check(d == 0, "R1 past window reads 0", d, 0);
    rd(302, d); check(d == 399, "R1 last reg unchanged", d, 399);
    wr(41, 32'hABCD_0015); rd(40, d);
    check(d == 32'h15, "R8 R9 truncation and odd offset", d, 32'h15);
    src_irq = '0; src_irq[21] = 1; #1;
    check(irq_out[20] == 1, "R9 routing from odd-offset write", irq_out[20], 1);
  endtask

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    t_reset;
    t_route;
    t_oob;
    t_bypass;
    t_window;
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule